// File: doc/BRIEF.md
# Four-Stage Bidirectional Shift Register with Bus-Capable Outputs

This block is a small synchronous register of `WIDTH` stages (four by default). Two mode selects choose what happens on each rising clock edge: the stages load from a parallel word, move one place toward the high end, move one place toward the low end, or clear to zero. It has no hold mode and no reset pin. The only way to bring it to a known value is a clock edge with both selects low.

The parallel output goes through three-state drivers, so several of these registers, or other agents, can share one bus. When the enable input is low the block releases every output line. It keeps clocking and updating its stored word while its lines are released. After power-up the user must apply one clear cycle before the stored value means anything.

Top module: `usr_tristate_shreg`

## Requirements
- R1: The stored word, and so the driven output, changes only at a rising clock edge. A change on the selects, the parallel word or the serial inputs between edges leaves the output unchanged.
- R2: With `sel1`=1 and `sel0`=1, the next edge copies `par_in` into the stages bit for bit. Neither serial input affects the result.
- R3: With `sel1`=0 and `sel0`=1 (toward high end), the next edge moves each bit n into bit n+1 and puts `ser_right` into bit 0.
- R4: With `sel1`=1 and `sel0`=0 (toward low end), the next edge moves each bit n into bit n-1 and puts `ser_left` into bit `WIDTH`-1.
- R5: With `sel1`=0 and `sel0`=0, the next edge sets every stage to 0.
- R6: While `out_en` is 0 the block drives no output line: every bit of `q_bus` is high impedance, and another driver on the same lines sets their value.
- R7: While `out_en` is 1, `q_bus` shows the stored word. It follows `out_en` without waiting for a clock edge.
- R8: `out_en` never changes the stored word. Load, both shifts and clear act the same way while the outputs are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every state change |
| sel0 | input | 1 | Mode select, low bit |
| sel1 | input | 1 | Mode select, high bit |
| par_in | input | WIDTH | Parallel word for the load mode |
| ser_right | input | 1 | Serial bit that enters stage 0 when shifting toward the high end |
| ser_left | input | 1 | Serial bit that enters the top stage when shifting toward the low end |
| out_en | input | 1 | 1 drives the stored word onto `q_bus`; 0 releases it |
| q_bus | output | WIDTH | Three-state parallel output |

## Verification
Each mode's result reaches `q_bus` one edge after the selects are applied, because there is one register stage and a combinational output path. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and compares at the following falling edge. The output enable has no register in its path, so its effect is checked a short delay after it changes and between edges. In that same window the bench also moves the other inputs and confirms that nothing else changes until the next edge. The released state is judged by driving complementary patterns onto the shared lines from the bench and reading them back.

// File: rtl/usr_pkg.sv
// Package: shared operation encoding for the bidirectional shift register.
// Assumes the mode pair is presented as {sel1, sel0}.
package usr_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'b00,
        OP_UP    = 2'b01,
        OP_DOWN  = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;
endpackage

// File: rtl/usr_mode_decode.sv
// Module: turns the two raw mode selects into the shared operation type.
// Assumes the selects are stable around the rising clock edge.
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic sel0,
    input  logic sel1,
    output op_e  op
);
    // Purpose: map {sel1, sel0} onto the operation enumeration.
    always_comb begin
        unique case ({sel1, sel0})
            2'b00:   op = OP_CLEAR;
            2'b01:   op = OP_UP;
            2'b10:   op = OP_DOWN;
            default: op = OP_LOAD;
        endcase
    end
endmodule

// File: rtl/usr_stage.sv
// Module: one storage stage with its next-value selector.
// Assumes the parent wires lower_bit/upper_bit to the neighbouring stages
// or, at the ends, to the serial inputs. There is no reset: the value is
// undefined until the first clear operation.
module usr_stage
    import usr_pkg::*;
(
    input  logic clk,
    input  op_e  op,
    input  logic par_bit,
    input  logic lower_bit,
    input  logic upper_bit,
    output logic q
);
    logic next_q;

    // Purpose: choose the value this stage takes on the next edge.
    always_comb begin
        unique case (op)
            OP_CLEAR: next_q = 1'b0;
            OP_UP:    next_q = lower_bit;
            OP_DOWN:  next_q = upper_bit;
            default:  next_q = par_bit;
        endcase
    end

    // Purpose: store the selected value on the rising edge.
    always_ff @(posedge clk) begin
        q <= next_q;
    end
endmodule

// File: rtl/usr_out_drive.sv
// Module: three-state output drivers for the parallel word.
// Assumes another agent may drive the same lines while enable is low.
module usr_out_drive #(
    parameter int WIDTH = 4
) (
    input  logic             en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] pins
);
    // Purpose: drive each line from its stage, or release it.
    for (genvar i = 0; i < WIDTH; i++) begin : g_drv
        assign pins[i] = en ? data[i] : 1'bz;
    end
endmodule

// File: rtl/usr_tristate_shreg.sv
// Module: top of the bidirectional shift register with bus-capable outputs.
// Assumes one clear cycle is applied before the stored word is used.
module usr_tristate_shreg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sel0,
    input  logic             sel1,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_right,
    input  logic             ser_left,
    input  logic             out_en,
    output logic [WIDTH-1:0] q_bus
);
    localparam int TOP = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] state_q;

    usr_mode_decode u_dec (
        .sel0 (sel0),
        .sel1 (sel1),
        .op   (op)
    );

    // Purpose: build the chain of stages with serial inputs at both ends.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lo_src;
        logic hi_src;
        if (i == 0) begin : g_lo_end
            assign lo_src = ser_right;
        end else begin : g_lo_mid
            assign lo_src = state_q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign hi_src = ser_left;
        end else begin : g_hi_mid
            assign hi_src = state_q[i+1];
        end
        usr_stage u_stage (
            .clk       (clk),
            .op        (op),
            .par_bit   (par_in[i]),
            .lower_bit (lo_src),
            .upper_bit (hi_src),
            .q         (state_q[i])
        );
    end

    usr_out_drive #(.WIDTH(WIDTH)) u_drv (
        .en   (out_en),
        .data (state_q),
        .pins (q_bus)
    );
endmodule

// File: rtl/usr_tristate_shreg_chk.sv
// Module: property checker bound to the shift register top.
// Assumes nothing holds before the first clear edge, so checks are armed by it.
module usr_tristate_shreg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             sel0,
    input logic             sel1,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_right,
    input logic             ser_left,
    input logic             out_en,
    input logic [WIDTH-1:0] q_bus,
    input logic [WIDTH-1:0] state
);
    logic armed = 1'b0;

    // Purpose: arm the checks once a clear edge has defined the state.
    always_ff @(posedge clk) begin
        if (!sel0 && !sel1) armed <= 1'b1;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
        (sel0 && sel1) |=> (state == $past(par_in)));

    assert_shift_up_R3: assert property (@(posedge clk) disable iff (!armed)
        (sel0 && !sel1) |=> (state == {$past(state[WIDTH-2:0]), $past(ser_right)}));

    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!armed)
        (!sel0 && sel1) |=> (state == {$past(ser_left), $past(state[WIDTH-1:1])}));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!armed)
        (!sel0 && !sel1) |=> (state == '0));

    assert_drive_R7: assert property (@(posedge clk) disable iff (!armed)
        out_en |-> (q_bus == state));
endmodule

bind usr_tristate_shreg usr_tristate_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .sel0      (sel0),
    .sel1      (sel1),
    .par_in    (par_in),
    .ser_right (ser_right),
    .ser_left  (ser_left),
    .out_en    (out_en),
    .q_bus     (q_bus),
    .state     (state_q)
);

// File: tb/usr_tristate_shreg_bench.sv
module usr_tristate_shreg_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         sel0, sel1, ser_right, ser_left, out_en;
    logic [W-1:0] par_in;
    logic         tb_drive;
    logic [W-1:0] tb_val;
    wire  [W-1:0] bus;
    logic [W-1:0] model;
    int           vectors = 0;
    int           misses = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    assign bus = tb_drive ? tb_val : {W{1'bz}};

    usr_tristate_shreg #(.WIDTH(W)) u_usr_tristate_shreg (
        .clk       (clk),
        .sel0      (sel0),
        .sel1      (sel1),
        .par_in    (par_in),
        .ser_right (ser_right),
        .ser_left  (ser_left),
        .out_en    (out_en),
        .q_bus     (bus)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs now (falling edge), pass one rising edge, return at next falling edge.
    task automatic step(input logic [1:0] m, input logic [W-1:0] d,
                        input logic sr, input logic sl, input logic oe);
        {sel1, sel0} = m;
        par_in = d; ser_right = sr; ser_left = sl; out_en = oe;
        @(posedge clk);
        case (m)
            2'b00: model = '0;
            2'b01: model = {model[W-2:0], sr};
            2'b10: model = {sl, model[W-1:1]};
            default: model = d;
        endcase
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00: return "R5";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        tb_drive = 1'b0; tb_val = '0; model = '0;
        sel0 = 1'b0; sel1 = 1'b0; par_in = '0;
        ser_right = 1'b0; ser_left = 1'b0; out_en = 1'b1;
        @(negedge clk);
        // First clear defines the state (R5).
        step(2'b00, 4'hF, 1'b1, 1'b1, 1'b1);
        check("R5", bus, 4'h0);
        // Released lines follow the other driver (R6).
        out_en = 1'b0; tb_drive = 1'b1; tb_val = 4'b1010; #1;
        check("R6", bus, 4'b1010);
        tb_val = 4'b0101; #1;
        check("R6", bus, 4'b0101);
        tb_drive = 1'b0; out_en = 1'b1; #1;
        check("R7", bus, 4'h0);

        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 16; d++) begin
                    for (int ss = 0; ss < 4; ss++) begin
                        automatic logic [1:0] mm = 2'(m);
                        automatic logic oe = ((s + d + ss) % 3) != 0;
                        // Load the start word, serial inputs set to disturb (R2).
                        step(2'b11, 4'(s), ss[0], ss[1], 1'b1);
                        check("R2", bus, 4'(s));
                        if (!oe) begin
                            tb_drive = 1'b1;
                            tb_val = d[0] ? 4'b0101 : 4'b1010;
                        end
                        step(mm, 4'(d), ss[0], ss[1], oe);
                        if (!oe) begin
                            check("R6", bus, tb_val);
                            tb_drive = 1'b0; out_en = 1'b1; #1;
                            check("R8", bus, model);
                        end else begin
                            check(req_of(mm), bus, model);
                        end
                        // Move every non-clock input between edges (R1).
                        par_in = ~par_in; sel0 = ~sel0; sel1 = ~sel1;
                        ser_right = ~ser_right; ser_left = ~ser_left; #1;
                        check("R1", bus, model);
                        @(negedge clk);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule